// File: doc/BRIEF.md
# Keyed Configuration Port

This block is the configuration front end of a legacy-style I/O controller. The host reaches it through two byte-wide ports: an index port that names a configuration register, and a data port that reads or writes that register. After reset the configuration space is sealed. Only a fixed key, written byte by byte to the index port, opens it. Until the key is complete, the index port acts only as the input of the key matcher.

Once the space is open, the registers below 0x30 are global. These include a control register that re-seals the space, a logical-device selector, a read-only 16-bit identity, and a revision nibble. Register numbers from 0x70 upward are passed to the logical device named by the selector, on a simple strobe interface with combinational read data. The gap between the global and device ranges reads as zero. Address decoding of the host bus happens outside the block: a single select input chooses between the index port and the data port.

Top module: `cfg_keyed_port`

## Requirements
- R1: After reset the space is sealed (`cfg_open` low), the key matcher is at its first byte, the register number and the device selector are 0x00, and `bus_rdata` holds 0xFF.
- R2: Index-port writes of 0x87, 0x01, 0x55 and 0x55, in that order, open the space. `cfg_open` rises on the clock edge that takes the last key byte.
- R3: A byte that does not match the next expected key byte sends the matcher back to its start. If that byte is 0x87, it counts as the first key byte.
- R4: While the space is sealed, data-port writes change no register and raise no device strobe. Reads of either port return 0xFF, and index-port writes do not change the register number.
- R5: While the space is open, an index-port write sets the register number, and an index-port read returns it.
- R6: Register 0x07 is the logical-device selector. It reads back what was written and drives `dev_ldn`. It changes only on a data-port write while register 0x07 is selected.
- R7: Registers 0x20 and 0x21 return the high and low bytes of the CHIP_ID parameter (0xA51C by default). Writes to them have no effect.
- R8: Register 0x22 returns the CHIP_REV parameter (0x3 by default) in bits 3:0, with zeros in bits 7:4.
- R9: For register numbers 0x70 and above, a data-port write pulses `dev_wr` in the same cycle, with `dev_reg`, `dev_ldn` and `dev_wdata` valid. A data-port read pulses `dev_rd` and returns `dev_rdata`.
- R10: Register numbers 0x30 to 0x6F, and the unused global numbers, read 0x00 and raise no device strobe.
- R11: A data-port write with bit 1 set to register 0x02 seals the space on that clock edge. Opening it again needs the full key. Register 0x02 reads 0x00.
- R12: Read data appears on `bus_rdata` on the clock edge that takes the read strobe. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_port | input | 1 | Port select: 0 index port, 1 data port |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte |
| cfg_open | output | 1 | Configuration space is open |
| dev_wr | output | 1 | Write strobe to the selected logical device |
| dev_rd | output | 1 | Read strobe to the selected logical device |
| dev_ldn | output | 8 | Selected logical-device number |
| dev_reg | output | 8 | Register number forwarded to the device |
| dev_wdata | output | 8 | Write byte forwarded to the device |
| dev_rdata | input | 8 | Read byte from the device, combinational |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, the four-byte key, and the registered read path (READ_REG = 1). This puts the retry rule within reach of the key matcher, including a repeated 0x87 in the middle of the key. It also reaches re-sealing through register 0x02 followed by a second unlock. The bench models the device as a combinational function of the selector and the register number, so each forwarded read has a distinct expected byte. Random traffic biased toward key bytes moves the block between the sealed and open states many times.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

   typedef enum logic [1:0] {
      RGN_GLOBAL = 2'd0,
      RGN_HOLE   = 2'd1,
      RGN_DEVICE = 2'd2
   } region_e;

   localparam logic PORT_INDEX = 1'b0;
   localparam logic PORT_DATA  = 1'b1;

endpackage

// File: rtl/cfg_key_matcher.sv
module cfg_key_matcher #(
   parameter int                      DW      = 8,
   parameter int                      KEY_LEN = 4,
   parameter logic [KEY_LEN*DW-1:0]   KEY     = 32'h8701_5555
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic [DW-1:0] byte_in,
   output logic          hit_o
);
   localparam int           CW   = $clog2(KEY_LEN);
   localparam logic [CW-1:0] LAST = CW'(KEY_LEN - 1);

   logic [DW-1:0] key_b [KEY_LEN];
   logic [CW-1:0] stage_q;
   logic          match;

   for (genvar i = 0; i < KEY_LEN; i++) begin : g_key
      assign key_b[i] = KEY[(KEY_LEN-1-i)*DW +: DW];
   end

   assign match = (byte_in == key_b[stage_q]);
   assign hit_o = step && match && (stage_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (step) begin
         if (match) begin
            stage_q <= (stage_q == LAST) ? '0 : stage_q + CW'(1);
         end else if (byte_in == key_b[0]) begin
            stage_q <= CW'(1);
         end else begin
            stage_q <= '0;
         end
      end
   end
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
   import cfgport_pkg::*;
#(
   parameter int                DW         = 8,
   parameter int                REV_W      = 4,
   parameter logic [2*DW-1:0]   CHIP_ID    = 16'hA51C,
   parameter logic [REV_W-1:0]  CHIP_REV   = 4'h3,
   parameter logic [DW-1:0]     CTRL_REG   = 8'h02,
   parameter logic [DW-1:0]     LDN_REG    = 8'h07,
   parameter logic [DW-1:0]     ID_REG     = 8'h20,
   parameter logic [DW-1:0]     REV_REG    = 8'h22,
   parameter logic [DW-1:0]     GLOBAL_TOP = 8'h30,
   parameter logic [DW-1:0]     DEV_BASE   = 8'h70,
   parameter int                LOCK_BIT   = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          open,
   input  logic          wr_index,
   input  logic          wr_data,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] index_q,
   output logic [DW-1:0] ldn_q,
   output logic          relock,
   output region_e       region,
   output logic [DW-1:0] glob_rdata
);
   localparam logic [DW-1:0] ID_LO_REG = ID_REG + DW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         index_q <= '0;
         ldn_q   <= '0;
      end else if (open) begin
         if (wr_index) index_q <= wdata;
         if (wr_data && index_q == LDN_REG) ldn_q <= wdata;
      end
   end

   assign relock = open && wr_data && (index_q == CTRL_REG) && wdata[LOCK_BIT];

   always_comb begin
      if (index_q < GLOBAL_TOP)      region = RGN_GLOBAL;
      else if (index_q >= DEV_BASE)  region = RGN_DEVICE;
      else                           region = RGN_HOLE;
   end

   always_comb begin
      glob_rdata = '0;
      if (index_q == LDN_REG)        glob_rdata = ldn_q;
      else if (index_q == ID_REG)    glob_rdata = CHIP_ID[2*DW-1:DW];
      else if (index_q == ID_LO_REG) glob_rdata = CHIP_ID[DW-1:0];
      else if (index_q == REV_REG)   glob_rdata = DW'(CHIP_REV);
   end
endmodule

// File: rtl/cfg_read_path.sv
module cfg_read_path
   import cfgport_pkg::*;
#(
   parameter int DW       = 8,
   parameter bit READ_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd,
   input  logic          port,
   input  logic          open,
   input  logic [DW-1:0] index_q,
   input  region_e       region,
   input  logic [DW-1:0] glob_rdata,
   input  logic [DW-1:0] dev_rdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] sel;

   always_comb begin
      if (!open)                    sel = '1;
      else if (port == PORT_INDEX)  sel = index_q;
      else begin
         unique case (region)
            RGN_GLOBAL: sel = glob_rdata;
            RGN_DEVICE: sel = dev_rdata;
            default:    sel = '0;
         endcase
      end
   end

   if (READ_REG) begin : g_reg
      logic [DW-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  rdata_q <= '1;
         else if (rd) rdata_q <= sel;
      end
      assign rdata = rdata_q;
   end else begin : g_comb
      assign rdata = sel;
   end
endmodule

// File: rtl/cfg_keyed_port.sv
module cfg_keyed_port
   import cfgport_pkg::*;
#(
   parameter int                      DW         = 8,
   parameter int                      KEY_LEN    = 4,
   parameter logic [KEY_LEN*DW-1:0]   KEY        = 32'h8701_5555,
   parameter int                      REV_W      = 4,
   parameter logic [2*DW-1:0]         CHIP_ID    = 16'hA51C,
   parameter logic [REV_W-1:0]        CHIP_REV   = 4'h3,
   parameter logic [DW-1:0]           CTRL_REG   = 8'h02,
   parameter logic [DW-1:0]           LDN_REG    = 8'h07,
   parameter logic [DW-1:0]           ID_REG     = 8'h20,
   parameter logic [DW-1:0]           REV_REG    = 8'h22,
   parameter logic [DW-1:0]           GLOBAL_TOP = 8'h30,
   parameter logic [DW-1:0]           DEV_BASE   = 8'h70,
   parameter int                      LOCK_BIT   = 1,
   parameter bit                      READ_REG   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic          bus_port,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          cfg_open,
   output logic          dev_wr,
   output logic          dev_rd,
   output logic [DW-1:0] dev_ldn,
   output logic [DW-1:0] dev_reg,
   output logic [DW-1:0] dev_wdata,
   input  logic [DW-1:0] dev_rdata
);
   if (KEY_LEN < 2) begin : g_bad_key
      $error("KEY_LEN must be at least 2");
   end
   if (REV_W > DW) begin : g_bad_rev
      $error("REV_W must not exceed DW");
   end
   if (LOCK_BIT >= DW) begin : g_bad_lock
      $error("LOCK_BIT must lie inside the data byte");
   end
   if (GLOBAL_TOP > DEV_BASE) begin : g_bad_map
      $error("GLOBAL_TOP must not exceed DEV_BASE");
   end

   logic          open_q;
   logic          key_hit;
   logic          relock;
   logic [DW-1:0] idx_q;
   logic [DW-1:0] ldn_q;
   logic [DW-1:0] glob_rdata;
   region_e       region;
   logic          wr_index, wr_data;

   assign wr_index = bus_wr && (bus_port == PORT_INDEX);
   assign wr_data  = bus_wr && (bus_port == PORT_DATA);

   cfg_key_matcher #(.DW(DW), .KEY_LEN(KEY_LEN), .KEY(KEY)) u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (wr_index && !open_q),
      .byte_in (bus_wdata),
      .hit_o   (key_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       open_q <= 1'b0;
      else if (relock)  open_q <= 1'b0;
      else if (key_hit) open_q <= 1'b1;
   end

   cfg_global_regs #(
      .DW(DW), .REV_W(REV_W), .CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV),
      .CTRL_REG(CTRL_REG), .LDN_REG(LDN_REG), .ID_REG(ID_REG), .REV_REG(REV_REG),
      .GLOBAL_TOP(GLOBAL_TOP), .DEV_BASE(DEV_BASE), .LOCK_BIT(LOCK_BIT)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .open       (open_q),
      .wr_index   (wr_index),
      .wr_data    (wr_data),
      .wdata      (bus_wdata),
      .index_q    (idx_q),
      .ldn_q      (ldn_q),
      .relock     (relock),
      .region     (region),
      .glob_rdata (glob_rdata)
   );

   cfg_read_path #(.DW(DW), .READ_REG(READ_REG)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd         (bus_rd),
      .port       (bus_port),
      .open       (open_q),
      .index_q    (idx_q),
      .region     (region),
      .glob_rdata (glob_rdata),
      .dev_rdata  (dev_rdata),
      .rdata      (bus_rdata)
   );

   assign cfg_open  = open_q;
   assign dev_wr    = wr_data && open_q && (region == RGN_DEVICE);
   assign dev_rd    = bus_rd && (bus_port == PORT_DATA) && open_q && (region == RGN_DEVICE);
   assign dev_ldn   = ldn_q;
   assign dev_reg   = idx_q;
   assign dev_wdata = bus_wdata;
endmodule

// File: rtl/cfg_keyed_port_chk.sv
module cfg_keyed_port_chk #(
   parameter int            DW       = 8,
   parameter logic [DW-1:0] CTRL_REG = 8'h02,
   parameter logic [DW-1:0] LDN_REG  = 8'h07,
   parameter int            LOCK_BIT = 1,
   parameter bit            READ_REG = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr,
   input logic          bus_rd,
   input logic          bus_port,
   input logic [DW-1:0] bus_wdata,
   input logic [DW-1:0] bus_rdata,
   input logic          cfg_open,
   input logic          dev_wr,
   input logic          dev_rd,
   input logic [DW-1:0] dev_ldn,
   input logic [DW-1:0] idx_q,
   input logic          key_hit
);
   // R4
   locked_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open |-> (!dev_wr && !dev_rd));

   // R2
   key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_hit |=> cfg_open);

   // R11
   relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && bus_wr && bus_port && idx_q == CTRL_REG && bus_wdata[LOCK_BIT]) |=> !cfg_open);

   // R6
   ldn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_open && bus_wr && bus_port && idx_q == LDN_REG) |=> $stable(dev_ldn));

   // R9
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_wr && dev_rd));

   if (READ_REG) begin : g_rd_chk
      // R12
      rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !bus_rd |=> $stable(bus_rdata));

      // R4
      locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && !cfg_open) |=> (bus_rdata == '1));
   end
endmodule

bind cfg_keyed_port cfg_keyed_port_chk #(
   .DW(DW), .CTRL_REG(CTRL_REG), .LDN_REG(LDN_REG),
   .LOCK_BIT(LOCK_BIT), .READ_REG(READ_REG)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_port  (bus_port),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .cfg_open  (cfg_open),
   .dev_wr    (dev_wr),
   .dev_rd    (dev_rd),
   .dev_ldn   (dev_ldn),
   .idx_q     (idx_q),
   .key_hit   (key_hit)
);

// File: tb/cfg_keyed_port_tb.sv
`timescale 1ns/1ps
module cfg_keyed_port_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_port = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       cfg_open, dev_wr, dev_rd;
   logic [7:0] dev_ldn, dev_reg, dev_wdata, dev_rdata;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   // bench model state
   int   m_stage = 0;
   bit   m_open  = 0;
   logic [7:0] m_idx = 8'h00;
   logic [7:0] m_ldn = 8'h00;

   always #4 clk = ~clk;

   // device model: combinational read byte
   assign dev_rdata = dev_ldn ^ dev_reg ^ 8'h5A;

   cfg_keyed_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cfg_open(cfg_open), .dev_wr(dev_wr), .dev_rd(dev_rd),
      .dev_ldn(dev_ldn), .dev_reg(dev_reg), .dev_wdata(dev_wdata),
      .dev_rdata(dev_rdata)
   );

   function automatic logic [7:0] key_at(input int i);
      case (i)
         0: return 8'h87;
         1: return 8'h01;
         default: return 8'h55;
      endcase
   endfunction

   function automatic logic [7:0] exp_read(input bit port);
      if (!m_open) return 8'hFF;
      if (!port) return m_idx;
      if (m_idx >= 8'h70) return m_ldn ^ m_idx ^ 8'h5A;
      if (m_idx >= 8'h30) return 8'h00;
      case (m_idx)
         8'h07: return m_ldn;
         8'h20: return 8'hA5;
         8'h21: return 8'h1C;
         8'h22: return 8'h03;
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic do_wr(input bit port, input logic [7:0] d, input string tag);
      bit exp_dev;
      @(negedge clk);
      bus_wr = 1'b1; bus_port = port; bus_wdata = d;
      #1;
      exp_dev = m_open && port && (m_idx >= 8'h70);
      check(dev_wr == exp_dev, {tag, " dev_wr"}, 8'(dev_wr), 8'(exp_dev));
      if (exp_dev) begin
         check(dev_reg == m_idx, {tag, " dev_reg"}, dev_reg, m_idx);
         check(dev_ldn == m_ldn, {tag, " dev_ldn"}, dev_ldn, m_ldn);
         check(dev_wdata == d, {tag, " dev_wdata"}, dev_wdata, d);
      end
      // model update
      if (!port) begin
         if (m_open) m_idx = d;
         else if (d == key_at(m_stage)) begin
            if (m_stage == 3) begin m_open = 1; m_stage = 0; end
            else m_stage++;
         end else m_stage = (d == 8'h87) ? 1 : 0;
      end else if (m_open) begin
         if (m_idx == 8'h07) m_ldn = d;
         if (m_idx == 8'h02 && d[1]) m_open = 0;
      end
      @(negedge clk);
      bus_wr = 1'b0;
      check(cfg_open == m_open, {tag, " cfg_open"}, 8'(cfg_open), 8'(m_open));
   endtask

   task automatic do_rd(input bit port, input string tag);
      logic [7:0] e;
      bit exp_dev;
      e = exp_read(port);
      @(negedge clk);
      bus_rd = 1'b1; bus_port = port;
      #1;
      exp_dev = m_open && port && (m_idx >= 8'h70);
      check(dev_rd == exp_dev, {tag, " dev_rd"}, 8'(dev_rd), 8'(exp_dev));
      @(negedge clk);
      bus_rd = 1'b0;
      check(bus_rdata == e, {tag, " rdata"}, bus_rdata, e);
   endtask

   task automatic send_key();
      for (int i = 0; i < 4; i++) do_wr(1'b0, key_at(i), "R2 key");
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] held;
      void'($urandom(32'd7411));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(cfg_open == 1'b0, "R1 open", 8'(cfg_open), 8'h0);
      check(bus_rdata == 8'hFF, "R1 rdata", bus_rdata, 8'hFF);
      check(dev_ldn == 8'h00 && dev_reg == 8'h00, "R1 regs", dev_ldn | dev_reg, 8'h00);
      // R4 sealed accesses
      do_rd(1'b1, "R4 data read");
      do_rd(1'b0, "R4 index read");
      do_wr(1'b1, 8'hC3, "R4 data write");
      // R3 wrong byte, then repeated first byte
      do_wr(1'b0, 8'h87, "R3"); do_wr(1'b0, 8'h01, "R3");
      do_wr(1'b0, 8'h55, "R3"); do_wr(1'b0, 8'h12, "R3 bad");
      check(cfg_open == 1'b0, "R3 stays sealed", 8'(cfg_open), 8'h0);
      do_wr(1'b0, 8'h87, "R3"); do_wr(1'b0, 8'h87, "R3 restart");
      do_wr(1'b0, 8'h01, "R3"); do_wr(1'b0, 8'h55, "R3"); do_wr(1'b0, 8'h55, "R2 open");
      check(cfg_open == 1'b1, "R2 opened", 8'(cfg_open), 8'h1);
      // R5 index
      do_wr(1'b0, 8'h20, "R5 idx"); do_rd(1'b0, "R5 idx read");
      // R7 identity, read-only
      do_rd(1'b1, "R7 id hi"); do_wr(1'b1, 8'h00, "R7 id write"); do_rd(1'b1, "R7 id hi kept");
      do_wr(1'b0, 8'h21, "R7 idx"); do_rd(1'b1, "R7 id lo");
      // R8 revision
      do_wr(1'b0, 8'h22, "R8 idx"); do_rd(1'b1, "R8 rev");
      // R6 selector
      do_wr(1'b0, 8'h07, "R6 idx"); do_wr(1'b1, 8'h07, "R6 ldn"); do_rd(1'b1, "R6 ldn read");
      check(dev_ldn == 8'h07, "R6 dev_ldn", dev_ldn, 8'h07);
      // R9 forwarding
      do_wr(1'b0, 8'h75, "R9 idx"); do_wr(1'b1, 8'h3C, "R9 fwd write"); do_rd(1'b1, "R9 fwd read");
      do_wr(1'b0, 8'hFF, "R9 idx top"); do_rd(1'b1, "R9 fwd read top");
      // R10 hole and unused global
      do_wr(1'b0, 8'h50, "R10 idx"); do_rd(1'b1, "R10 hole read"); do_wr(1'b1, 8'h99, "R10 hole write");
      do_wr(1'b0, 8'h2F, "R10 idx"); do_rd(1'b1, "R10 unused global");
      // R12 read data held
      do_rd(1'b1, "R12 read");
      held = bus_rdata;
      repeat (3) @(negedge clk);
      check(bus_rdata == held, "R12 held", bus_rdata, held);
      // R11 re-seal
      do_wr(1'b0, 8'h02, "R11 idx"); do_rd(1'b1, "R11 ctrl read");
      do_wr(1'b1, 8'h02, "R11 relock");
      check(cfg_open == 1'b0, "R11 sealed", 8'(cfg_open), 8'h0);
      do_rd(1'b1, "R11 sealed read");
      do_wr(1'b0, 8'h07, "R4 sealed idx write");
      send_key();
      do_rd(1'b0, "R4 idx unchanged");
      // random traffic
      for (int n = 0; n < 600; n++) begin
         int r;
         r = int'($urandom_range(0, 9));
         if (!m_open) begin
            if (r < 6) do_wr(1'b0, key_at(m_stage), "R2 rand key");
            else if (r < 8) do_wr(1'b0, 8'($urandom), "R3 rand key");
            else do_rd(r[0], "R4 rand sealed");
         end else begin
            if (r < 3) begin
               logic [7:0] ix;
               case ($urandom_range(0, 7))
                  0: ix = 8'h02; 1: ix = 8'h07; 2: ix = 8'h20; 3: ix = 8'h22;
                  4: ix = 8'h45; 5: ix = 8'h70; 6: ix = 8'hA3;
                  default: ix = 8'($urandom);
               endcase
               do_wr(1'b0, ix, "R5 rand idx");
            end else if (r < 6) do_wr(1'b1, 8'($urandom), "R9 rand data write");
            else do_rd(r[0], "R9 rand read");
         end
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule